// File: doc/BRIEF.md
# Lane-Partitioned SIMD Adder

This block turns a single 32-bit adder into several narrower ones. A mode input chooses the lane width: four 8-bit lanes, two 16-bit lanes, or one 32-bit lane kept as a comparison and pass mode. The carry chain is cut wherever a lane ends, so every lane adds or subtracts its own pair of fields at the same time as the others, and no lane's result depends on another lane's data. Results wrap modulo the lane width and are never saturated.

Every lane also reports one greater-or-equal flag. For unsigned addition the flag is the lane's carry out. For unsigned subtraction it means no borrow. For signed operations it means the mathematically exact result is non-negative. The flag vector is always four bits wide. A lane wider than 8 bits drives its flag onto every 8-bit position it covers. Subtraction inverts the second operand and injects a carry-in of one at the bottom of every lane.

Operands and controls are captured together with the result on one clock edge. Result and flags appear one cycle after the inputs are presented.

Top module: `simd_lane_adder`

## Requirements
- R1: While `rstN` is low, `sumOut` and `geFlags` are zero, whatever the inputs.
- R2: With `laneMode` = 2'b00, `sumOut[8k+7:8k]` one cycle later equals the sum or difference of the matching operand bytes modulo 256, for k = 0..3. No carry or borrow crosses bit 7, 15 or 23.
- R3: With `laneMode` = 2'b01, `sumOut[15:0]` and `sumOut[31:16]` are independent 16-bit results modulo 65536. Only bit 15 is a cut point, and carries do cross bits 7 and 23.
- R4: With `laneMode` = 2'b10 or 2'b11, `sumOut` is the full 32-bit sum or difference modulo 2^32.
- R5: With `subOp` = 1, every lane computes A minus B and wraps. With `subOp` = 0, every lane computes A plus B.
- R6: For unsigned addition (`signedOp` = 0, `subOp` = 0), a lane's flag is 1 exactly when the exact lane sum is at least 2^W, where W is the lane width.
- R7: For unsigned subtraction (`signedOp` = 0, `subOp` = 1), a lane's flag is 1 exactly when the A field is at least the B field as unsigned numbers.
- R8: With `signedOp` = 1, a lane's flag is 1 exactly when the exact two's-complement sum or difference of the lane fields is greater than or equal to zero, even when the wrapped result overflows.
- R9: `geFlags[i]` belongs to byte i. In 16-bit mode, bits 1:0 both carry the low lane's flag and bits 3:2 both carry the high lane's flag. In 32-bit mode all four bits carry the single flag.
- R10: `signedOp` changes only the flags. `sumOut` is the same for either value of `signedOp`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are captured on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 32 | First packed operand |
| opB | input | 32 | Second packed operand (subtrahend when subtracting) |
| laneMode | input | 2 | 00: four 8-bit lanes, 01: two 16-bit lanes, 1x: one 32-bit lane |
| signedOp | input | 1 | 1 selects signed flag meaning |
| subOp | input | 1 | 1 selects subtraction, 0 addition |
| sumOut | output | 32 | Registered packed lane results |
| geFlags | output | 4 | Registered per-byte greater-or-equal flags |

## Verification
The bench drives operands whose bytes sit at 0x00, 0x7F, 0x80 and 0xFF. These values force carries and borrows right at bits 7, 15 and 23, so a lane boundary that leaks a carry in one mode, or one that is wrongly cut in a wider mode, shows up as a wrong neighbouring lane. Signed overflow cases such as 0x7F+0x01 and 0x80-0x01 set the signed flag against the wrapped sign bit, which tells the exact-result flag apart from a plain copy of the sign bit. Long runs of random operands in all three modes, with every combination of add, subtract, signed and unsigned, are compared every cycle against a lane-by-lane integer model. Pairs of cycles that differ only in `signedOp` show that the sum bits ignore it.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

  parameter int DATA_W  = 32;
  parameter int SLICE_W = 8;
  localparam int SLICES = DATA_W / SLICE_W;

  typedef enum logic [1:0] {
    LANE_B8   = 2'd0,
    LANE_B16  = 2'd1,
    LANE_W32  = 2'd2,
    LANE_W32X = 2'd3
  } laneMode_e;

  typedef enum logic [1:0] {
    FLAG_SLICE = 2'd0,
    FLAG_PAIR  = 2'd1,
    FLAG_WHOLE = 2'd2
  } flagGroup_e;

  typedef struct packed {
    logic [SLICES-1:0] cutBelow;  // slice i takes the injected carry
    logic              carryInj;
    logic              invertB;
    logic              signedCmp;
    flagGroup_e        flagGroup;
  } laneStrobes_t;

endpackage

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl
  import simd_lane_pkg::*;
(
  input  logic [1:0]   laneMode,
  input  logic         signedOp,
  input  logic         subOp,
  output laneStrobes_t strobes
);

  laneMode_e modeSel;

  always_comb begin
    modeSel = laneMode_e'(laneMode);
    strobes.carryInj  = subOp;
    strobes.invertB   = subOp;
    strobes.signedCmp = signedOp;
    strobes.cutBelow  = '0;
    strobes.flagGroup = FLAG_WHOLE;
    unique case (modeSel)
      LANE_B8: begin
        strobes.cutBelow  = '1;
        strobes.flagGroup = FLAG_SLICE;
      end
      LANE_B16: begin
        for (int i = 0; i < SLICES; i += 2) strobes.cutBelow[i] = 1'b1;
        strobes.flagGroup = FLAG_PAIR;
      end
      default: begin
        strobes.cutBelow[0] = 1'b1;
        strobes.flagGroup   = FLAG_WHOLE;
      end
    endcase
  end

endmodule

// File: rtl/simd_lane_dp.sv
module simd_lane_dp
  import simd_lane_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  laneStrobes_t      strobes,
  output logic [DATA_W-1:0] sumComb,
  output logic [SLICES-1:0] flagComb
);

  logic [SLICES-1:0] topFlag;

  always_comb begin
    logic              carry;
    logic [SLICE_W-1:0] aS, bS;
    logic [SLICE_W:0]   part;
    carry   = strobes.carryInj;
    sumComb = '0;
    topFlag = '0;
    for (int i = 0; i < SLICES; i++) begin
      aS = opA[i*SLICE_W +: SLICE_W];
      bS = opB[i*SLICE_W +: SLICE_W] ^ {SLICE_W{strobes.invertB}};
      if (strobes.cutBelow[i]) carry = strobes.carryInj;
      part = {1'b0, aS} + {1'b0, bS} + {{SLICE_W{1'b0}}, carry};
      sumComb[i*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
      // flag this slice would give if it were the top of a lane
      topFlag[i] = strobes.signedCmp ?
                   ~(aS[SLICE_W-1] ^ bS[SLICE_W-1] ^ part[SLICE_W]) :
                   part[SLICE_W];
      carry = part[SLICE_W];
    end
  end

  for (genvar i = 0; i < SLICES; i++) begin : g_flag
    always_comb begin
      unique case (strobes.flagGroup)
        FLAG_SLICE: flagComb[i] = topFlag[i];
        FLAG_PAIR:  flagComb[i] = topFlag[i | 1];
        default:    flagComb[i] = topFlag[SLICES-1];
      endcase
    end
  end

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_lane_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [1:0]  laneMode,
  input  logic        signedOp,
  input  logic        subOp,
  output logic [31:0] sumOut,
  output logic [3:0]  geFlags
);

  laneStrobes_t      strobes;
  logic [DATA_W-1:0] sumComb;
  logic [SLICES-1:0] flagComb;
  logic              primed;

  simd_lane_ctrl u_ctrl (
    .laneMode (laneMode),
    .signedOp (signedOp),
    .subOp    (subOp),
    .strobes  (strobes)
  );

  simd_lane_dp u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .sumComb  (sumComb),
    .flagComb (flagComb)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumOut  <= '0;
      geFlags <= '0;
      primed  <= 1'b0;
    end else begin
      sumOut  <= sumComb;
      geFlags <= flagComb;
      primed  <= 1'b1;
    end
  end

  // R2: byte lane 1 never sees the carry out of byte lane 0
  p_lane1_isolated_r2: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(laneMode == 2'b00 && !subOp) |->
      sumOut[15:8] == 8'($past(opA[15:8]) + $past(opB[15:8])));

  // R4: the pass mode is a plain 32-bit adder
  p_pass_add_r4: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(laneMode[1] && !subOp) |->
      sumOut == 32'($past(opA) + $past(opB)));

  // R7: top byte lane flag is the unsigned compare when subtracting
  p_no_borrow_r7: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(laneMode == 2'b00 && subOp && !signedOp) |->
      geFlags[3] == ($past(opA[31:24]) >= $past(opB[31:24])));

  // R9: each 16-bit lane drives both of its flag positions
  p_pair_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(laneMode == 2'b01) |->
      (geFlags[0] == geFlags[1]) && (geFlags[2] == geFlags[3]));

  // R9: the single 32-bit lane drives all flag positions
  p_whole_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(laneMode[1]) |->
      ($countones(geFlags) == 0) || ($countones(geFlags) == 4));

endmodule

// File: tb/simd_lane_adder_tb_top.sv
module simd_lane_adder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0]  laneMode = '0;
  logic        signedOp = 1'b0, subOp = 1'b0;
  logic [31:0] sumOut;
  logic [3:0]  geFlags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          pending = 1'b0;
  logic [31:0] expSum;
  logic [3:0]  expFlags;
  string       sumTag, flagTag;

  always #4 clk = ~clk;  // 125 MHz

  simd_lane_adder dut_i (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .laneMode(laneMode),
    .signedOp(signedOp), .subOp(subOp), .sumOut(sumOut), .geFlags(geFlags)
  );

  task automatic model(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] mode, input logic sgn, input logic sub,
                       output logic [31:0] es, output logic [3:0] ef);
    int w;
    w = (mode == 2'b00) ? 8 : (mode == 2'b01) ? 16 : 32;
    es = '0;
    ef = '0;
    for (int k = 0; k < 32 / w; k++) begin
      longint mask, ua, ub, sa, sb, r, ex;
      bit f;
      mask = (longint'(1) <<< w) - 1;
      ua = (longint'(a) >>> (k * w)) & mask;
      ub = (longint'(b) >>> (k * w)) & mask;
      sa = (ua >= (longint'(1) <<< (w - 1))) ? ua - (longint'(1) <<< w) : ua;
      sb = (ub >= (longint'(1) <<< (w - 1))) ? ub - (longint'(1) <<< w) : ub;
      r  = sub ? ua - ub : ua + ub;
      es = es | 32'((r & mask) <<< (k * w));
      if (sgn) begin
        ex = sub ? sa - sb : sa + sb;
        f  = (ex >= 0);
      end else if (sub) begin
        f = (ua >= ub);
      end else begin
        f = (r >= (longint'(1) <<< w));
      end
      for (int j = 0; j < w / 8; j++) ef[k * (w / 8) + j] = f;
    end
  endtask

  task automatic checkPending();
    if (pending) begin
      checks++;
      if (sumOut !== expSum) begin
        errors++;
        $display("FAIL %s sum: actual %h expected %h", sumTag, sumOut, expSum);
      end
      checks++;
      if (geFlags !== expFlags) begin
        errors++;
        $display("FAIL %s flags: actual %b expected %b", flagTag, geFlags, expFlags);
      end
    end
  endtask

  // called at a falling edge: check the previous cycle, then drive the next
  task automatic step(input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] mode, input logic sgn, input logic sub);
    checkPending();
    opA = a; opB = b; laneMode = mode; signedOp = sgn; subOp = sub;
    model(a, b, mode, sgn, sub, expSum, expFlags);
    sumTag  = $sformatf("%s%s%s", (mode == 2'b00) ? "R2" : (mode == 2'b01) ? "R3" : "R4",
                        sub ? "/R5" : "", sgn ? "/R10" : "");
    flagTag = $sformatf("%s%s", sgn ? "R8" : (sub ? "R7" : "R6"),
                        (mode != 2'b00) ? "/R9" : "");
    pending = 1'b1;
    @(negedge clk);
  endtask

  task automatic bothSigns(input logic [31:0] a, input logic [31:0] b,
                           input logic [1:0] mode, input logic sub);
    step(a, b, mode, 1'b0, sub);
    step(a, b, mode, 1'b1, sub);
  endtask

  initial begin
    // R1: reset holds outputs low even with live inputs
    opA = 32'hFFFF_FFFF; opB = 32'h0000_0001; laneMode = 2'b10;
    repeat (3) @(negedge clk);
    checks++;
    if (sumOut !== 32'h0 || geFlags !== 4'h0) begin
      errors++;
      $display("FAIL R1 reset: actual %h/%b expected 00000000/0000", sumOut, geFlags);
    end
    rstN = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 2; s++) begin
        bothSigns(32'hFF01_FF01, 32'h01FF_0101, 2'(m), 1'(s));
        bothSigns(32'h7F80_7FFF, 32'h0101_8001, 2'(m), 1'(s));
        bothSigns(32'h0000_0000, 32'h0101_0101, 2'(m), 1'(s));
        bothSigns(32'hFFFF_FFFF, 32'h0000_0001, 2'(m), 1'(s));
        bothSigns(32'h8000_8000, 32'h8000_8000, 2'(m), 1'(s));
        bothSigns(32'h1234_5678, 32'h1234_5678, 2'(m), 1'(s));
      end
    end
    bothSigns(32'h5A5A_5A5A, 32'hA5A5_A5A5, 2'b11, 1'b0);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if (n % 3 == 0) a = a | 32'h8080_8080;
      if (n % 5 == 0) b = ~a;
      step(a, b, 2'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)));
    end
    checkPending();
    pending = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule